// File: doc/BRIEF.md
# Four-Phase Pattern Generator

This block is a free-running synchronous controller. On every rising clock edge it moves to the next of four fixed 4-bit output patterns. After the fourth pattern it returns to the first, and it keeps doing this for as long as the clock runs. The four patterns are 0001, 0011, 1100 and 1000, written with w as the leftmost bit. Such a rotating pattern can drive a row of lamps directly. It can also energise the windings of a stepper motor through suitable drivers.

The block has no data inputs. A synchronous reset sends it back to the first phase, and from there it steps unconditionally. Internally a small phase register holds the current step. A decoder forms the four output bits from that register alone, so the output is a Moore output and has no input-to-output path.

Parameters select how the phase is held and how it is decoded:
- The phase can be held in a compact 2-bit binary counter or in a 4-bit one-hot ring.
- The decode can use gate equations or a lookup.

The behaviour seen at the ports is the same in every variant.

Top module: `four_phase_pattern_gen`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `pattern_o` reads 4'b0001 after that edge, where bit 3 is w, bit 2 is x, bit 1 is y and bit 0 is z.
- R2: While `rst` is low, each rising edge advances `pattern_o` in the order 0001, 0011, 1100, 1000, and after 1000 the next pattern is 0001.
- R3: Each pattern is present for exactly one clock cycle, so `pattern_o` differs after every rising edge at which `rst` is low.
- R4: In every cycle after reset, bit 3 (w) is the complement of bit 0 (z), and bit 2 (x) and bit 1 (y) are never both 1.
- R5: Reset applied in any of the four phases, including the last phase where the sequence would wrap anyway, gives 0001 after the edge.
- R6: With `rst` low, `pattern_o` repeats with a period of four cycles, and this holds over any number of consecutive periods.
- R7: Reset is synchronous: raising `rst` between edges leaves `pattern_o` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the phase advances on the rising edge |
| rst | input | 1 | Synchronous reset, active high; returns the block to the first phase |
| pattern_o | output | 4 | Current pattern: bit 3 = w, bit 2 = x, bit 1 = y, bit 0 = z |

## Verification
The two actions that can fall on the same edge are the natural wrap from the last phase (1000) back to 0001 and a reset. Both lead to 0001, so a defect in either one can be hidden by the other. The bench applies reset in each of the four phases and includes the phase that reads 1000. It requires 0001 after every one of those edges. It then lets the block run free and requires 0011 on the following edge. This exposes a reset that was decoded only from the wrap, and a wrap that depended on reset.

// File: rtl/pgen_pkg.sv
// Shared types and helpers for the four-phase pattern generator.
package pgen_pkg;

   localparam int PHASE_W = 2;
   localparam int PAT_W   = 4;
   localparam int NUM_PHASES = 1 << PHASE_W;

   typedef enum logic [PHASE_W-1:0] {
      PH_FIRST  = 2'b00,
      PH_SECOND = 2'b01,
      PH_THIRD  = 2'b10,
      PH_FOURTH = 2'b11
   } phase_e;

   // Pattern produced in each phase, w in bit 3 down to z in bit 0.
   function automatic logic [PAT_W-1:0] pattern_of(input phase_e ph);
      logic [PAT_W-1:0] p;
      unique case (ph)
         PH_FIRST:  p = 4'b0001;
         PH_SECOND: p = 4'b0011;
         PH_THIRD:  p = 4'b1100;
         PH_FOURTH: p = 4'b1000;
         default:   p = 4'b0001;
      endcase
      return p;
   endfunction

   // Pattern expected one step after a given pattern.
   function automatic logic [PAT_W-1:0] pattern_after(input logic [PAT_W-1:0] p);
      logic [PAT_W-1:0] n;
      unique case (p)
         4'b0001: n = 4'b0011;
         4'b0011: n = 4'b1100;
         4'b1100: n = 4'b1000;
         4'b1000: n = 4'b0001;
         default: n = 4'bxxxx;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/pgen_phase_seq.sv
// Phase register: either a binary counter with gate-level next state,
// or a one-hot ring that rotates by one position per clock.
module pgen_phase_seq
   import pgen_pkg::*;
#(
   parameter bit USE_ONEHOT = 1'b0
) (
   input  logic   clk,
   input  logic   rst,
   output phase_e phase_o
);

   localparam int RING_W = NUM_PHASES;

   generate
      if (PHASE_W != 2) begin : g_bad_width
         $error("pgen_phase_seq: the phase register must be 2 bits wide");
      end

      if (USE_ONEHOT) begin : g_ring
         logic [RING_W-1:0] ring_q;

         always_ff @(posedge clk) begin
            if (rst) ring_q <= {{(RING_W-1){1'b0}}, 1'b1};
            else     ring_q <= {ring_q[RING_W-2:0], ring_q[RING_W-1]};
         end

         // The position of the set bit is the phase number.
         logic [PHASE_W-1:0] enc;
         always_comb begin
            enc[1] = ring_q[2] | ring_q[3];
            enc[0] = ring_q[1] | ring_q[3];
         end
         assign phase_o = phase_e'(enc);

         AST_RING_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
            (!rst) |=> ($countones(ring_q) == 1)) else $error("ring not one-hot"); // R2

      end else begin : g_binary
         logic s1_q, s0_q;
         logic n1, n0;

         always_comb begin
            n1 = s1_q ^ s0_q;
            n0 = ~s0_q;
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               s1_q <= 1'b0;
               s0_q <= 1'b0;
            end else begin
               s1_q <= n1;
               s0_q <= n0;
            end
         end

         assign phase_o = phase_e'({s1_q, s0_q});
      end
   endgenerate

   AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (!rst) |=> (phase_o == phase_e'(2'($past(phase_o)) + 2'd1))) else $error("phase skipped"); // R2

endmodule

// File: rtl/pgen_pattern_dec.sv
// Output decoder: gate equations on the phase bits or a lookup.
module pgen_pattern_dec
   import pgen_pkg::*;
#(
   parameter bit USE_TABLE = 1'b0
) (
   input  phase_e           phase_i,
   output logic [PAT_W-1:0] pattern_o
);

   generate
      if (PAT_W != 4) begin : g_bad_width
         $error("pgen_pattern_dec: the pattern must be 4 bits wide");
      end

      if (USE_TABLE) begin : g_table
         always_comb pattern_o = pattern_of(phase_i);
      end else begin : g_gates
         logic s1, s0;
         always_comb begin
            s1 = phase_i[1];
            s0 = phase_i[0];
            pattern_o[3] = s1;          // w
            pattern_o[2] = s1 & ~s0;    // x
            pattern_o[1] = ~s1 & s0;    // y
            pattern_o[0] = ~s1;         // z
         end
      end
   endgenerate

   // The outer bits are always opposite; the inner bits never both set.
   always_comb begin
      if (!$isunknown(phase_i)) begin
         AST_OUTER_OPPOSITE: assert (pattern_o[3] != pattern_o[0]) else $error("w equals z"); // R4
         AST_INNER_EXCLUSIVE: assert (!(pattern_o[2] && pattern_o[1])) else $error("x and y both set"); // R4
      end
   end

endmodule

// File: rtl/four_phase_pattern_gen.sv
// Top: free-running four-phase pattern generator with synchronous reset.
module four_phase_pattern_gen
   import pgen_pkg::*;
#(
   parameter bit USE_ONEHOT = 1'b0,
   parameter bit USE_TABLE  = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   output logic [3:0] pattern_o
);

   phase_e phase;

   pgen_phase_seq #(.USE_ONEHOT(USE_ONEHOT)) i_seq (
      .clk     (clk),
      .rst     (rst),
      .phase_o (phase)
   );

   pgen_pattern_dec #(.USE_TABLE(USE_TABLE)) i_dec (
      .phase_i   (phase),
      .pattern_o (pattern_o)
   );

   AST_RESET_TO_FIRST: assert property (@(posedge clk)
      rst |=> (pattern_o == 4'b0001)) else $error("reset did not give 0001"); // R1

   AST_PATTERN_ORDER: assert property (@(posedge clk) disable iff (rst)
      (!rst) |=> (pattern_o == pattern_after($past(pattern_o)))) else $error("wrong successor"); // R2

   AST_ONE_CYCLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!rst) |=> !$stable(pattern_o)) else $error("pattern held twice"); // R3

endmodule

// File: tb/test_four_phase_pattern_gen.sv
`timescale 1ns/1ps
module test_four_phase_pattern_gen;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] pattern_o;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   logic [3:0] seq_tab [4];
   initial begin
      seq_tab[0] = 4'b0001;
      seq_tab[1] = 4'b0011;
      seq_tab[2] = 4'b1100;
      seq_tab[3] = 4'b1000;
   end

   always #2.5 clk = ~clk;

   four_phase_pattern_gen i_four_phase_pattern_gen (
      .clk       (clk),
      .rst       (rst),
      .pattern_o (pattern_o)
   );

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: pattern_o=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // One clock step: inputs change and are sampled on the falling edge.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      rst = 1'b1;
      step();
      step();
      chk("R1 reset state", pattern_o, 4'b0001);
      rst = 1'b0;
   endtask

   // Three full periods and more, with the order, hold and period checked.
   task automatic t_free_run();
      logic [3:0] prev;
      logic [3:0] hist [4];
      rst = 1'b1; step(); rst = 1'b0;
      chk("R2 start", pattern_o, seq_tab[0]);
      hist[0] = pattern_o;
      for (int i = 1; i <= 16; i++) begin
         prev = pattern_o;
         step();
         chk("R2 order", pattern_o, seq_tab[i % 4]);
         checks++;
         if (pattern_o === prev) begin
            errors++;
            $display("FAIL R3 hold: pattern_o=%b expected change from %b", pattern_o, prev);
         end
         if (i >= 4) chk("R6 period", pattern_o, hist[i % 4]);
         hist[i % 4] = pattern_o;
      end
   endtask

   task automatic t_bit_relations();
      rst = 1'b1; step(); rst = 1'b0;
      for (int i = 0; i < 8; i++) begin
         chk("R4 w vs z", {3'b000, pattern_o[3]}, {3'b000, ~pattern_o[0]});
         chk("R4 x and y", {3'b000, pattern_o[2] & pattern_o[1]}, 4'b0000);
         step();
      end
   endtask

   // Reset in each phase; phase 3 shows 1000, where the wrap coincides.
   task automatic t_reset_each_phase();
      for (int k = 0; k < 4; k++) begin
         rst = 1'b1; step(); rst = 1'b0;
         for (int j = 0; j < k; j++) step();
         chk("R5 phase before reset", pattern_o, seq_tab[k]);
         rst = 1'b1;
         step();
         chk("R5 reset in phase", pattern_o, 4'b0001);
         rst = 1'b0;
         step();
         chk("R5 resume after reset", pattern_o, 4'b0011);
      end
   endtask

   task automatic t_sync_reset();
      rst = 1'b1; step(); rst = 1'b0;
      step(); step();
      chk("R7 setup", pattern_o, 4'b1100);
      #0.5 rst = 1'b1;
      #1.0;
      chk("R7 no async effect", pattern_o, 4'b1100);
      step();
      chk("R7 effect at edge", pattern_o, 4'b0001);
      rst = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      t_reset_state();
      t_free_run();
      t_bit_relations();
      t_reset_each_phase();
      t_sync_reset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule